// File: doc/BRIEF.md
# Four-Channel Pulse-Width DAC Bank

This block turns four 8-bit codes into four pulse-width-modulated logic outputs. A low-pass filter outside the chip turns each output into an analog level. A microcontroller writes each code through a small register port. The port has a channel select, a write strobe, write data and a read-back bus.

All four channels share one step prescaler and one frame counter. Two static control inputs set the timing. The first picks the step rate: a base rate, or twice that rate. The second picks the frame length: 256 steps or 253 steps. In the 253-step frame, the three highest codes hold the output high for the whole frame. In the 256-step frame, full scale still leaves one low step in each frame.

A written code is held in a shadow copy and only reaches the comparator when the frame restarts. This keeps partial pulses out of the output.

Top module: `pwm_dac_bank`

## Requirements
- R1: Each of the four channel registers can be written and read back. `reg_sel` (0 to 3) picks the channel for a write when `reg_wr` is high, and it picks the channel shown on `reg_rdata`. The read-back bus shows the register value as soon as the clock edge that stores the write has passed.
- R2: After reset, every channel register reads 80h. Each output is then high for 128 of the 256 steps in every frame.
- R3: With `short_frame`=0, a frame is 256 steps long. A channel holding code N is high for exactly N steps of each frame, and those steps come at the start of the frame.
- R4: With `short_frame`=1, a frame is 253 steps long. A channel holding code N is high for min(N,253) steps, so the codes FDh, FEh and FFh keep the output high for the whole frame.
- R5: With `short_frame`=0, the code FFh still drives the output low for exactly one step in every frame.
- R6: The code 00h keeps the output low in every mode.
- R7: One step lasts BASE_DIV clock cycles when `fast_sel`=0 and BASE_DIV/2 clock cycles when `fast_sel`=1.
- R8: A new code takes effect only at the next frame boundary. An output can rise only at the start of a frame, so its rising edges stay exactly one frame apart even when a write lands mid-frame.
- R9: A change on `fast_sel` or `short_frame` restarts the frame counter at the next step. Outside that one pending step, the counter never goes past the last step of the selected frame.
- R10: The channels are independent. Writing one channel leaves the codes and duty of the other three unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, also the prescaler source |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_sel | input | 2 | Channel select for write and read-back |
| reg_wr | input | 1 | Write strobe for the selected channel |
| reg_wdata | input | 8 | Code to write |
| reg_rdata | output | 8 | Stored code of the selected channel |
| fast_sel | input | 1 | 1 = double step rate |
| short_frame | input | 1 | 1 = 253-step frame, 0 = 256-step frame |
| pwm_out | output | 4 | One PWM output per channel |

## Verification
A corrupt frame counter or prescaler changes how many cycles each output spends high in a frame. It also changes the spacing between rising edges. Either fault shows at the pins within one frame, no more than 1024 clocks at the default divider.

A shadow register that loads at the wrong moment gives rising edges closer together than one frame. That appears in the frame where the write lands.

A wrong stored code shows at once on the read-back bus. Its effect on the duty count shows one frame later.

// File: rtl/pwm_dac_pkg.sv
// Package: constants and types shared by the PWM DAC bank.
// Assumes 8-bit codes; the frame wrap values follow from that width.
package pwm_dac_pkg;
    localparam int          CODE_W     = 8;
    localparam logic [7:0]  RESET_CODE = 8'h80;
    localparam logic [7:0]  WRAP_LONG  = 8'd255;   // last step of 256-step frame
    localparam logic [7:0]  WRAP_SHORT = 8'd252;   // last step of 253-step frame

    typedef struct packed {
        logic fast;
        logic short_frame;
    } pwm_mode_t;
endpackage

// File: rtl/pwm_step_gen.sv
// Step prescaler: emits a one-cycle step enable every BASE_DIV clocks,
// or every BASE_DIV/2 clocks when fast is set.
// Assumes BASE_DIV is even and at least 4, so a step is always >= 2 clocks.
module pwm_step_gen #(
    parameter int BASE_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fast,
    output logic step_en
);
    localparam int CW = (BASE_DIV > 2) ? $clog2(BASE_DIV) : 1;

    logic [CW-1:0] div_cnt;
    logic [CW-1:0] last_cnt;

    // Pick the terminal count for the selected rate.
    always_comb begin
        last_cnt = fast ? CW'(BASE_DIV/2 - 1) : CW'(BASE_DIV - 1);
        step_en  = (div_cnt >= last_cnt);
    end

    // Divider counter; >= guards a rate switch while above the new limit.
    always_ff @(posedge clk) begin
        if (!rst_n)       div_cnt <= '0;
        else if (step_en) div_cnt <= '0;
        else              div_cnt <= div_cnt + 1'b1;
    end

    // R7
    step_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> !step_en);

    initial begin
        if (BASE_DIV < 4 || (BASE_DIV % 2) != 0)
            $error("pwm_step_gen: BASE_DIV must be even and >= 4");
    end
endmodule

// File: rtl/pwm_frame_ctr.sv
// Shared frame counter: advances on each step and wraps at 252 or 255.
// A change of either mode input restarts it at the next step.
// Assumes mode inputs are synchronous to clk.
module pwm_frame_ctr
    import pwm_dac_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  pwm_mode_t        mode_in,
    output logic [CODE_W-1:0] frame_cnt,
    output logic             frame_load
);
    pwm_mode_t        mode_q;
    logic             pending_q;
    logic             mode_chg;
    logic             restart;
    logic [CODE_W-1:0] wrap_val;

    // Detect a mode change and pick the wrap value for the held mode.
    always_comb begin
        mode_chg   = (mode_in != mode_q);
        restart    = pending_q | mode_chg;
        wrap_val   = mode_q.short_frame ? WRAP_SHORT : WRAP_LONG;
        frame_load = step_en && (restart || frame_cnt == wrap_val);
    end

    // Hold the mode, remember a pending restart, and step the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= '0;
            pending_q <= 1'b0;
            frame_cnt <= '0;
        end else begin
            mode_q    <= mode_in;
            pending_q <= restart & ~step_en;
            if (step_en) begin
                if (frame_load) frame_cnt <= '0;
                else            frame_cnt <= frame_cnt + 1'b1;
            end
        end
    end

    // R9
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pending_q |-> (frame_cnt <= wrap_val));

    // R9
    load_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_load |=> (frame_cnt == '0));
endmodule

// File: rtl/pwm_channel.sv
// One channel: a software-visible code register, a shadow copy loaded at
// the frame boundary, and a registered compare that drives the output.
// Assumes frame_load coincides with the counter returning to zero.
module pwm_channel
    import pwm_dac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wdata,
    input  logic              frame_load,
    input  logic [CODE_W-1:0] frame_cnt,
    output logic [CODE_W-1:0] code_q,
    output logic              pwm_o
);
    logic [CODE_W-1:0] shadow_q;

    // Software-visible code register.
    always_ff @(posedge clk) begin
        if (!rst_n)     code_q <= RESET_CODE;
        else if (wr_en) code_q <= wdata;
    end

    // Shadow copy follows the code only at a frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)          shadow_q <= RESET_CODE;
        else if (frame_load) shadow_q <= code_q;
    end

    // Registered compare: high while the frame step is below the code.
    always_ff @(posedge clk) begin
        if (!rst_n) pwm_o <= 1'b0;
        else        pwm_o <= (frame_cnt < shadow_q);
    end

    // R6
    zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(shadow_q) == '0) |-> !pwm_o);
endmodule

// File: rtl/pwm_dac_bank.sv
// Top: four-channel PWM DAC bank with a register port. One prescaler and
// one frame counter feed NUM_CH channel slices.
// Assumes control inputs are synchronous to clk.
module pwm_dac_bank
    import pwm_dac_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int BASE_DIV = 4,
    localparam int SEL_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic              reg_wr,
    input  logic [CODE_W-1:0] reg_wdata,
    output logic [CODE_W-1:0] reg_rdata,
    input  logic              fast_sel,
    input  logic              short_frame,
    output logic [NUM_CH-1:0] pwm_out
);
    logic              step_en;
    logic              frame_load;
    logic [CODE_W-1:0] frame_cnt;
    pwm_mode_t         mode;
    logic [CODE_W-1:0] code_arr [NUM_CH];

    // Bundle the two control bits.
    always_comb begin
        mode.fast        = fast_sel;
        mode.short_frame = short_frame;
    end

    pwm_step_gen #(.BASE_DIV(BASE_DIV)) u_step (
        .clk     (clk),
        .rst_n   (rst_n),
        .fast    (fast_sel),
        .step_en (step_en)
    );

    pwm_frame_ctr u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_en    (step_en),
        .mode_in    (mode),
        .frame_cnt  (frame_cnt),
        .frame_load (frame_load)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        pwm_channel u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (reg_wr && (reg_sel == SEL_W'(i))),
            .wdata      (reg_wdata),
            .frame_load (frame_load),
            .frame_cnt  (frame_cnt),
            .code_q     (code_arr[i]),
            .pwm_o      (pwm_out[i])
        );

        // R8
        rise_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pwm_out[i]) |-> ($past(frame_cnt) == '0));
    end

    // Read-back mux for the selected channel.
    always_comb begin
        reg_rdata = code_arr[reg_sel];
    end

    // R1
    readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (!$stable(reg_sel) || reg_rdata == $past(reg_wdata)));
endmodule

// File: tb/pwm_dac_bank_tb.sv
module pwm_dac_bank_tb;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_sel = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       fast_sel = 1'b0;
    logic       short_frame = 1'b0;
    logic [3:0] pwm_out;

    int total = 0;
    int bad   = 0;
    int model [4];
    int hi_cnt [4];

    always #10 clk = ~clk;

    pwm_dac_bank #(.NUM_CH(4), .BASE_DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fast_sel(fast_sel),
        .short_frame(short_frame), .pwm_out(pwm_out)
    );

    function automatic int step_len(input logic fast);
        return fast ? DIV/2 : DIV;
    endfunction

    function automatic int frame_len(input logic sh, input logic fast);
        return (sh ? 253 : 256) * step_len(fast);
    endfunction

    function automatic int exp_high(input int v, input logic sh, input logic fast);
        int n;
        n = (sh && v > 253) ? 253 : v;
        return n * step_len(fast);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic write_reg(input int ch, input int v);
        @(negedge clk);
        reg_sel = 2'(ch); reg_wdata = 8'(v); reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        model[ch] = v;
    endtask

    task automatic measure(input int n);
        for (int c = 0; c < 4; c++) hi_cnt[c] = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            for (int c = 0; c < 4; c++) if (pwm_out[c]) hi_cnt[c]++;
        end
    endtask

    // Set code and mode, let it settle, then check every channel's duty.
    task automatic run_case(input string tag, input int ch, input int v,
                            input logic sh, input logic fast);
        write_reg(ch, v);
        reg_sel = 2'(ch);
        @(negedge clk);
        check({tag, " R1 readback"}, int'(reg_rdata), v);
        short_frame = sh; fast_sel = fast;
        repeat (3 * 256 * DIV) @(negedge clk);
        measure(frame_len(sh, fast));
        for (int c = 0; c < 4; c++)
            check($sformatf("%s R10 duty ch%0d", tag, c), hi_cnt[c],
                  exp_high(model[c], sh, fast));
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int c = 0; c < 4; c++) model[c] = 8'h80;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R2: reset codes and mid-scale duty
        for (int c = 0; c < 4; c++) begin
            reg_sel = 2'(c);
            @(negedge clk);
            check($sformatf("R2 reset code ch%0d", c), int'(reg_rdata), 8'h80);
        end
        repeat (2 * 256 * DIV) @(negedge clk);
        measure(256 * DIV);
        for (int c = 0; c < 4; c++)
            check($sformatf("R2 reset duty ch%0d", c), hi_cnt[c], 128 * DIV);

        // Directed corners
        run_case("R6 zero long",   0, 8'h00, 1'b0, 1'b0);
        run_case("R6 zero short",  0, 8'h00, 1'b1, 1'b1);
        run_case("R5 full long",   1, 8'hFF, 1'b0, 1'b0);
        run_case("R4 FD short",    2, 8'hFD, 1'b1, 1'b0);
        run_case("R4 FE short",    2, 8'hFE, 1'b1, 1'b0);
        run_case("R4 FF short",    1, 8'hFF, 1'b1, 1'b0);
        run_case("R4 FC short",    3, 8'hFC, 1'b1, 1'b0);
        run_case("R7 fast long",   3, 8'h40, 1'b0, 1'b1);
        run_case("R3 mid long",    0, 8'h01, 1'b0, 1'b0);
        run_case("R9 back short",  0, 8'h90, 1'b1, 1'b1);

        // R8: mid-frame write must not give an early rising edge
        run_case("R8 setup", 0, 8'h20, 1'b0, 1'b0);
        begin
            int t, last_rise, rises, short_gaps;
            logic prev;
            prev = pwm_out[0];
            while (!(pwm_out[0] && !prev)) begin
                prev = pwm_out[0];
                @(negedge clk);
            end
            last_rise = 0; t = 0; rises = 0; short_gaps = 0;
            repeat (64 * DIV) begin @(negedge clk); t++; end
            prev = pwm_out[0];
            write_reg(0, 8'hC0); t += 2;
            for (int k = 0; k < 3 * 256 * DIV; k++) begin
                @(negedge clk); t++;
                if (pwm_out[0] && !prev) begin
                    if (t - last_rise != 256 * DIV) short_gaps++;
                    last_rise = t; rises++;
                end
                prev = pwm_out[0];
            end
            check("R8 rise spacing errors", short_gaps, 0);
            check("R8 rises seen", rises, 3);
        end

        // Random cases, R3/R4/R7/R10
        for (int i = 0; i < 10; i++) begin
            int ch, v;
            logic sh, fa;
            ch = int'($urandom % 4);
            v  = int'($urandom % 256);
            if (i % 4 == 0) v = 250 + int'($urandom % 6);
            sh = 1'($urandom % 2);
            fa = 1'($urandom % 2);
            run_case($sformatf("R3 rand%0d", i), ch, v, sh, fa);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule